// File: doc/BRIEF.md
# PCI configuration access sequencer

This block sits between a host-side register interface and a PCI initiator. It takes a configuration read or write request that names a bus, a device slot, a function, a byte offset and an access size. From these it builds the configuration address. Bus 0 uses the Type 0 form, with the slot turned into a one-hot device-select bit. Any other bus uses the Type 1 form. The block then runs one single-word transfer through a simple request/acknowledge initiator port that also returns an abort flag.

Reads of 8 or 16 bits fetch the aligned dword and return the addressed lanes, zero-extended. Writes of 8 or 16 bits are done as read-modify-write: the block reads the aligned dword, replaces the addressed lanes and writes the merged dword back. Requests with bad arguments are refused before any bus cycle. A master abort returns all-ones data and sets a sticky abort flag, which software clears by writing 1 to it. Each request ends with a one-cycle done pulse carrying a status code.

Top module: `cfg_access_seq`

## Requirements
- R1: When the bus number is 0, the initiator address is Type 0: bit (11+slot) is the only bit set in bits 31:11, function sits in bits 10:8, offset bits 7:2 sit in bits 7:2, and bits 1:0 are 00. For slot 21 the select bit would fall above bit 31, so no bit is set in 31:11.
- R2: When the bus number is not 0, the address is Type 1: bus in bits 23:16, slot in bits 15:11, function in bits 10:8, offset bits 7:2 in bits 7:2, bit 1 = 0, bit 0 = 1 and bits 31:24 = 0.
- R3: A request with slot above 21, with size code 3, or with a 32-bit size (code 2) and offset bits 1:0 not 00 completes with status 2 (invalid) and issues no initiator transfer.
- R4: A 16-bit request (size code 1) with an odd offset completes with status 2 and issues no initiator transfer.
- R5: A read whose transfer aborts returns all-ones masked to the access width and status 1. Any aborted transfer sets abort_sticky on the next cycle. A cycle with abort_clr = 1 clears it, unless an abort arrives in the same cycle.
- R6: An 8-bit (code 0) or 16-bit read issues one read at offset & 0xFC and returns (dword >> 8*(offset & 3)) masked to the width, zero-extended.
- R7: An 8-bit or 16-bit write first reads the aligned dword. It then writes back that dword with only the addressed lanes replaced by the low bits of req_wdata.
- R8: A 16-bit write whose read phase aborts completes with status 1 and issues no write phase.
- R9: An 8-bit write whose read phase aborts still writes, merging its lanes into all-ones. Its status is that of the write phase.
- R10: busy is high from the cycle after acceptance through the done cycle. While it is high, req_valid is ignored, and no transfer starts after done unless a new request arrives.
- R11: done is a one-cycle pulse, one cycle after the last initiator acknowledge or after acceptance of an invalid request. status is 0 = OK, 1 = master abort, 2 = invalid.
- R12: A 32-bit read issues one read and returns the dword. A 32-bit write issues one write of req_wdata with no read phase and returns status 0 or 1 from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_slot | input | 5 | Device slot |
| req_func | input | 3 | Function number |
| req_offset | input | 8 | Byte offset in configuration space |
| req_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| req_wdata | input | 32 | Write data, right-aligned for sub-word sizes |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Completion code |
| rdata | output | 32 | Read result, valid with done on reads |
| abort_sticky | output | 1 | Sticky master-abort flag |
| abort_clr | input | 1 | Write-1-to-clear for abort_sticky |
| ini_req | output | 1 | Initiator transfer request |
| ini_write | output | 1 | Initiator transfer direction |
| ini_addr | output | 32 | Configuration address |
| ini_wdata | output | 32 | Initiator write dword |
| ini_ack | input | 1 | Initiator completion |
| ini_abort | input | 1 | Completion ended in master abort |
| ini_rdata | input | 32 | Initiator read dword |

## Verification
The checker watches every cycle for the address-format rules: a single select bit on Type 0, a clean top byte and bit 0 set on Type 1, and bit 1 always clear. It also checks that a pending initiator request stays stable, that invalid requests go straight to done with no transfer, that done lasts one cycle and falls within busy, and that the sticky abort flag sets and clears. Lane extraction, read-modify-write merging, the two different reactions of 16-bit and 8-bit writes to a read abort, and the discarding of requests made while busy depend on data and on the order of phases. Only the bench scenarios show these, checked against a byte-lane model of each request.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  localparam int BUS_W  = 8;
  localparam int SLOT_W = 5;
  localparam int FUNC_W = 3;
  localparam int OFS_W  = 8;
  localparam int DW     = 32;
  localparam int SH_W   = $clog2(DW);
  localparam int IDSEL_BASE = 11;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_ABORT   = 2'd1,
    ST_INVALID = 2'd2
  } cfg_status_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } cfg_size_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RD,
    S_WR,
    S_RESP
  } seq_state_e;

  typedef struct packed {
    logic             write;
    logic [1:0]       size;
    logic [OFS_W-1:0] offset;
    logic [DW-1:0]    wdata;
  } cfg_req_t;

  // Type 0 for bus 0, Type 1 otherwise.
  function automatic logic [DW-1:0] cfg_address(
    input logic [BUS_W-1:0]  bus,
    input logic [SLOT_W-1:0] slot,
    input logic [FUNC_W-1:0] func,
    input logic [OFS_W-1:0]  offset
  );
    logic [2*DW-1:0] sel;
    logic [DW-1:0]   a;
    sel = {{(2*DW-1){1'b0}}, 1'b1} << (32'(slot) + 32'(IDSEL_BASE));
    a = '0;
    a[10:8] = func;
    a[7:2]  = offset[7:2];
    if (bus == '0) begin
      a = a | sel[DW-1:0];
    end else begin
      a[23:16] = bus;
      a[15:11] = slot;
      a[0]     = 1'b1;
    end
    return a;
  endfunction

  function automatic logic req_args_ok(
    input logic [SLOT_W-1:0] slot,
    input logic [OFS_W-1:0]  offset,
    input logic [1:0]        size,
    input int                max_slot
  );
    logic ok;
    ok = (32'(slot) <= max_slot);
    case (size)
      SZ_BYTE: ok = ok;
      SZ_HALF: ok = ok && !offset[0];
      SZ_WORD: ok = ok && (offset[1:0] == 2'b00);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic [SH_W-1:0] lane_shift(input logic [OFS_W-1:0] offset);
    return {offset[1:0], 3'b000};
  endfunction

  function automatic logic [DW-1:0] lane_mask(input logic [1:0] size);
    case (size)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [DW-1:0] lane_extract(
    input logic [DW-1:0]    word,
    input logic [OFS_W-1:0] offset,
    input logic [1:0]       size
  );
    return (word >> lane_shift(offset)) & lane_mask(size);
  endfunction

  function automatic logic [DW-1:0] lane_merge(
    input logic [DW-1:0]    old_word,
    input logic [DW-1:0]    new_data,
    input logic [OFS_W-1:0] offset,
    input logic [1:0]       size
  );
    logic [DW-1:0] m;
    m = lane_mask(size) << lane_shift(offset);
    return (old_word & ~m) | ((new_data << lane_shift(offset)) & m);
  endfunction

endpackage

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
  import cfg_seq_pkg::*;
#(
  parameter int MAX_SLOT = 21
) (
  input  logic [BUS_W-1:0]  bus,
  input  logic [SLOT_W-1:0] slot,
  input  logic [FUNC_W-1:0] func,
  input  logic [OFS_W-1:0]  offset,
  input  logic [1:0]        size,
  output logic [DW-1:0]     addr,
  output logic              args_ok
);

  always_comb begin
    addr    = cfg_address(bus, slot, func, offset);
    args_ok = req_args_ok(slot, offset, size, MAX_SLOT);
  end

endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit
  import cfg_seq_pkg::*;
(
  input  logic [DW-1:0]    rd_word,
  input  logic             rd_abort,
  input  logic [DW-1:0]    wdata,
  input  logic [OFS_W-1:0] offset,
  input  logic [1:0]       size,
  output logic [DW-1:0]    rd_lanes,
  output logic [DW-1:0]    merged
);

  logic [DW-1:0] src;

  // An aborted read stands for an all-ones dword.
  always_comb begin
    src      = rd_abort ? {DW{1'b1}} : rd_word;
    rd_lanes = lane_extract(src, offset, size);
    merged   = lane_merge(src, wdata, offset, size);
  end

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [DW-1:0]    req_wdata,
  input  logic [DW-1:0]    addr_in,
  input  logic             addr_ok,
  input  logic             ini_ack,
  input  logic             ini_abort,
  input  logic [DW-1:0]    lane_rd,
  input  logic [DW-1:0]    lane_merged,
  output seq_state_e       state,
  output cfg_req_t         cap,
  output logic [DW-1:0]    addr_q,
  output logic [DW-1:0]    wdata_q,
  output logic [DW-1:0]    rdata_q,
  output logic [1:0]       status_q,
  output logic             accept,
  output logic             acc_invalid
);

  assign accept      = (state == S_IDLE) && req_valid;
  assign acc_invalid = accept && !addr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cap      <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      status_q <= ST_OK;
    end else begin
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            cap.write  <= req_write;
            cap.size   <= req_size;
            cap.offset <= req_offset;
            cap.wdata  <= req_wdata;
            addr_q     <= addr_in;
            if (!addr_ok) begin
              status_q <= ST_INVALID;
              state    <= S_RESP;
            end else if (req_write && (req_size == SZ_WORD)) begin
              wdata_q <= req_wdata;
              state   <= S_WR;
            end else begin
              state <= S_RD;
            end
          end
        end
        S_RD: begin
          if (ini_ack) begin
            if (!cap.write) begin
              rdata_q  <= lane_rd;
              status_q <= ini_abort ? ST_ABORT : ST_OK;
              state    <= S_RESP;
            end else if (ini_abort && (cap.size == SZ_HALF)) begin
              status_q <= ST_ABORT;
              state    <= S_RESP;
            end else begin
              wdata_q <= lane_merged;
              state   <= S_WR;
            end
          end
        end
        S_WR: begin
          if (ini_ack) begin
            status_q <= ini_abort ? ST_ABORT : ST_OK;
            state    <= S_RESP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_access_seq.sv
module cfg_access_seq
  import cfg_seq_pkg::*;
#(
  parameter int MAX_SLOT = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [1:0]        req_size,
  input  logic [DW-1:0]     req_wdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [DW-1:0]     rdata,
  output logic              abort_sticky,
  input  logic              abort_clr,
  output logic              ini_req,
  output logic              ini_write,
  output logic [DW-1:0]     ini_addr,
  output logic [DW-1:0]     ini_wdata,
  input  logic              ini_ack,
  input  logic              ini_abort,
  input  logic [DW-1:0]     ini_rdata
);

  logic [DW-1:0] gen_addr;
  logic          gen_ok;
  logic [DW-1:0] lane_rd;
  logic [DW-1:0] lane_merged;
  seq_state_e    state;
  cfg_req_t      cap;
  logic [DW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          accept;
  logic          acc_invalid;
  logic          xfer_done;
  logic          abort_evt;

  cfg_addr_gen #(.MAX_SLOT(MAX_SLOT)) u_addr (
    .bus     (req_bus),
    .slot    (req_slot),
    .func    (req_func),
    .offset  (req_offset),
    .size    (req_size),
    .addr    (gen_addr),
    .args_ok (gen_ok)
  );

  cfg_lane_unit u_lane (
    .rd_word  (ini_rdata),
    .rd_abort (ini_abort),
    .wdata    (cap.wdata),
    .offset   (cap.offset),
    .size     (cap.size),
    .rd_lanes (lane_rd),
    .merged   (lane_merged)
  );

  cfg_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_size    (req_size),
    .req_offset  (req_offset),
    .req_wdata   (req_wdata),
    .addr_in     (gen_addr),
    .addr_ok     (gen_ok),
    .ini_ack     (ini_ack),
    .ini_abort   (ini_abort),
    .lane_rd     (lane_rd),
    .lane_merged (lane_merged),
    .state       (state),
    .cap         (cap),
    .addr_q      (addr_q),
    .wdata_q     (wdata_q),
    .rdata_q     (rdata),
    .status_q    (status),
    .accept      (accept),
    .acc_invalid (acc_invalid)
  );

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_RESP);
  assign ini_req   = (state == S_RD) || (state == S_WR);
  assign ini_write = (state == S_WR);
  assign ini_addr  = addr_q;
  assign ini_wdata = wdata_q;
  assign xfer_done = ini_req && ini_ack;
  assign abort_evt = xfer_done && ini_abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_sticky <= 1'b0;
    end else begin
      abort_sticky <= (abort_sticky && !abort_clr) || abort_evt;
    end
  end

endmodule

// File: rtl/cfg_access_seq_chk.sv
module cfg_access_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [1:0]  status,
  input logic        ini_req,
  input logic        ini_ack,
  input logic        ini_write,
  input logic [31:0] ini_addr,
  input logic        abort_sticky,
  input logic        abort_clr,
  input logic        acc_invalid,
  input logic        abort_evt
);

  // R1
  type0_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ini_req && !ini_addr[0]) |-> ($countones(ini_addr[31:11]) <= 1));

  // R2
  type1_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ini_req && ini_addr[0]) |-> (ini_addr[31:24] == 8'h00));

  // R1
  addr_bit1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ini_req |-> !ini_addr[1]);

  // R3
  invalid_nobus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_invalid |=> (done && !ini_req && (status == 2'd2)));

  // R5
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> abort_sticky);

  // R5
  sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_clr && !abort_evt) |=> !abort_sticky);

  // R10
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ini_req |-> busy);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ini_req && !ini_ack) |=> (ini_req && $stable(ini_addr) && $stable(ini_write)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !ini_req && (status != 2'd3)));

endmodule

bind cfg_access_seq cfg_access_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .status       (status),
  .ini_req      (ini_req),
  .ini_ack      (ini_ack),
  .ini_write    (ini_write),
  .ini_addr     (ini_addr),
  .abort_sticky (abort_sticky),
  .abort_clr    (abort_clr),
  .acc_invalid  (acc_invalid),
  .abort_evt    (abort_evt)
);

// File: tb/cfg_access_seq_tb.sv
module cfg_access_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_slot = '0;
  logic [2:0]  req_func = '0;
  logic [7:0]  req_offset = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, abort_sticky, ini_req, ini_write;
  logic [1:0]  status;
  logic [31:0] rdata, ini_addr, ini_wdata;
  logic        abort_clr = 1'b0, ini_ack = 1'b0, ini_abort = 1'b0;
  logic [31:0] ini_rdata = '0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  int          nph;
  logic [31:0] ph_addr [2];
  logic        ph_wr   [2];
  logic [31:0] ph_data [2];
  logic [1:0]  got_st;
  logic [31:0] got_rd;
  logic        got_done;

  always #5 clk = ~clk;

  cfg_access_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bus(req_bus), .req_slot(req_slot), .req_func(req_func),
    .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
    .busy(busy), .done(done), .status(status), .rdata(rdata),
    .abort_sticky(abort_sticky), .abort_clr(abort_clr),
    .ini_req(ini_req), .ini_write(ini_write), .ini_addr(ini_addr),
    .ini_wdata(ini_wdata), .ini_ack(ini_ack), .ini_abort(ini_abort),
    .ini_rdata(ini_rdata)
  );

  task automatic summary_and_end();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      summary_and_end();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
  endfunction

  function automatic logic [31:0] model_addr(input logic [7:0] bus, input logic [4:0] slot,
                                             input logic [2:0] func, input logic [7:0] off);
    logic [31:0] r;
    r = {24'd0, off & 8'hFC} + ({29'd0, func} * 32'd256);
    if (bus == 8'd0) begin
      if (slot < 5'd21) r = r + (32'd1 << (32'(slot) + 32'd11));
    end else begin
      r = r + ({24'd0, bus} * 32'd65536) + ({27'd0, slot} * 32'd2048) + 32'd1;
    end
    return r;
  endfunction

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] model_ext(input logic [31:0] w, input logic [7:0] off,
                                            input logic [1:0] sz);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < nbytes(sz); k++)
      r[8*k +: 8] = w[8*(32'(off[1:0]) + k) +: 8];
    return r;
  endfunction

  function automatic logic [31:0] model_merge(input logic [31:0] w, input logic [31:0] d,
                                              input logic [7:0] off, input logic [1:0] sz);
    logic [31:0] r;
    r = w;
    for (int k = 0; k < nbytes(sz); k++)
      r[8*(32'(off[1:0]) + k) +: 8] = d[8*k +: 8];
    return r;
  endfunction

  task automatic run_req(input logic w, input logic [7:0] bus, input logic [4:0] slot,
                         input logic [2:0] func, input logic [7:0] off, input logic [1:0] sz,
                         input logic [31:0] wd, input logic ab_rd, input logic ab_wr,
                         input logic poke);
    int cnt;
    int lat;
    nph = 0; got_done = 1'b0; cnt = 0; lat = int'($urandom % 4);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_bus = bus; req_slot = slot;
    req_func = func; req_offset = off; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 60; cyc++) begin
      ini_ack = 1'b0; ini_abort = 1'b0;
      if (done) begin
        got_done = 1'b1; got_st = status; got_rd = rdata;
        req_valid = 1'b0;
        break;
      end
      if (poke && cyc == 1) begin
        req_valid = 1'b1; req_write = ~w; req_bus = 8'd0; req_slot = 5'd3;
        req_size = 2'd2; req_offset = 8'h10;
      end else begin
        req_valid = 1'b0;
      end
      if (ini_req) begin
        if (!busy) chk("R10 busy during transfer", {31'd0, busy}, 32'd1);
        if (cnt >= lat) begin
          if (nph < 2) begin
            ph_addr[nph] = ini_addr; ph_wr[nph] = ini_write; ph_data[nph] = ini_wdata;
          end
          nph = nph + 1;
          ini_ack = 1'b1;
          ini_abort = ini_write ? ab_wr : ab_rd;
          ini_rdata = pat(ini_addr);
          cnt = 0; lat = int'($urandom % 4);
        end else begin
          cnt = cnt + 1;
        end
      end
      @(negedge clk);
    end
    chk("R11 done seen", {31'd0, got_done}, 32'd1);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk("R10 idle after done", {30'd0, ini_req, busy}, 32'd0);
    end
  endtask

  task automatic check_req(input logic w, input logic [7:0] bus, input logic [4:0] slot,
                           input logic [2:0] func, input logic [7:0] off, input logic [1:0] sz,
                           input logic [31:0] wd, input logic ab_rd, input logic ab_wr,
                           input logic poke);
    logic        valid;
    logic [31:0] ea, base;
    int          enph;
    logic [1:0]  es;
    logic        any_ab;
    string       atag;
    run_req(w, bus, slot, func, off, sz, wd, ab_rd, ab_wr, poke);
    valid = (slot <= 5'd21) && (sz != 2'd3) && !(sz == 2'd1 && off[0]) &&
            !(sz == 2'd2 && off[1:0] != 2'b00);
    ea = model_addr(bus, slot, func, off);
    atag = (bus == 8'd0) ? "R1 address" : "R2 address";
    any_ab = 1'b0;
    if (!valid) begin
      chk((sz == 2'd1 && off[0] && slot <= 5'd21 ) ? "R4 status" : "R3 status",
          {30'd0, got_st}, 32'd2);
      chk("R3 no transfer", nph, 32'd0);
    end else if (!w) begin
      chk("R12 phases", nph, 32'd1);
      chk(atag, ph_addr[0], ea);
      chk("R11 read status", {30'd0, got_st}, {31'd0, ab_rd});
      if (ab_rd) chk("R5 abort data", got_rd, model_ext(32'hFFFF_FFFF, off, sz));
      else chk(sz == 2'd2 ? "R12 read data" : "R6 lane data", got_rd,
               model_ext(pat(ea), off, sz));
      any_ab = ab_rd;
    end else if (sz == 2'd2) begin
      chk("R12 phases", nph, 32'd1);
      chk("R12 write dir", {31'd0, ph_wr[0]}, 32'd1);
      chk(atag, ph_addr[0], ea);
      chk("R12 write data", ph_data[0], wd);
      chk("R12 write status", {30'd0, got_st}, {31'd0, ab_wr});
      any_ab = ab_wr;
    end else begin
      base = ab_rd ? 32'hFFFF_FFFF : pat(ea);
      enph = (sz == 2'd1 && ab_rd) ? 1 : 2;
      es = (enph == 1) ? 2'd1 : {1'b0, ab_wr};
      chk(sz == 2'd1 && ab_rd ? "R8 phases" : "R7 phases", nph, enph);
      chk(atag, ph_addr[0], ea);
      chk("R7 read first", {31'd0, ph_wr[0]}, 32'd0);
      chk(ab_rd ? (sz == 2'd1 ? "R8 status" : "R9 status") : "R11 status",
          {30'd0, got_st}, {30'd0, es});
      if (enph == 2 && nph == 2) begin
        chk("R7 write addr", ph_addr[1], ea);
        chk(ab_rd ? "R9 merged data" : "R7 merged data", ph_data[1],
            model_merge(base, wd, off, sz));
      end
      any_ab = ab_rd || (enph == 2 && ab_wr);
    end
    if (any_ab) begin
      chk("R5 sticky set", {31'd0, abort_sticky}, 32'd1);
      abort_clr = 1'b1;
      @(negedge clk);
      abort_clr = 1'b0;
      chk("R5 sticky cleared", {31'd0, abort_sticky}, 32'd0);
    end
  endtask

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset", {27'd0, busy, done, ini_req, abort_sticky, 1'b0}, 32'd0);

    check_req(1'b0, 8'd0, 5'd0,  3'd0, 8'h00, 2'd2, 32'd0, 1'b0, 1'b0, 1'b0);
    check_req(1'b0, 8'd0, 5'd21, 3'd5, 8'h3C, 2'd2, 32'd0, 1'b0, 1'b0, 1'b0);
    check_req(1'b0, 8'd5, 5'd20, 3'd7, 8'hFC, 2'd2, 32'd0, 1'b0, 1'b0, 1'b0);
    check_req(1'b0, 8'd0, 5'd22, 3'd0, 8'h00, 2'd2, 32'd0, 1'b0, 1'b0, 1'b0);
    check_req(1'b1, 8'd1, 5'd2,  3'd0, 8'h00, 2'd3, 32'd0, 1'b0, 1'b0, 1'b0);
    check_req(1'b0, 8'd0, 5'd2,  3'd0, 8'h02, 2'd2, 32'd0, 1'b0, 1'b0, 1'b0);
    check_req(1'b1, 8'd0, 5'd2,  3'd0, 8'h03, 2'd1, 32'd0, 1'b0, 1'b0, 1'b0);
    check_req(1'b0, 8'd0, 5'd4,  3'd1, 8'h0E, 2'd1, 32'd0, 1'b0, 1'b0, 1'b0);
    check_req(1'b0, 8'd3, 5'd4,  3'd1, 8'h0B, 2'd0, 32'd0, 1'b0, 1'b0, 1'b0);
    check_req(1'b1, 8'd0, 5'd6,  3'd2, 8'h06, 2'd1, 32'h1234_BEEF, 1'b0, 1'b0, 1'b0);
    check_req(1'b1, 8'd9, 5'd6,  3'd2, 8'h05, 2'd0, 32'h0000_00A5, 1'b0, 1'b0, 1'b0);
    check_req(1'b0, 8'd0, 5'd1,  3'd0, 8'h0D, 2'd0, 32'd0, 1'b1, 1'b0, 1'b0);
    check_req(1'b1, 8'd0, 5'd1,  3'd0, 8'h02, 2'd1, 32'h0000_5555, 1'b1, 1'b0, 1'b0);
    check_req(1'b1, 8'd0, 5'd1,  3'd0, 8'h02, 2'd0, 32'h0000_0033, 1'b1, 1'b0, 1'b0);
    check_req(1'b1, 8'd2, 5'd8,  3'd3, 8'h40, 2'd2, 32'hCAFE_F00D, 1'b0, 1'b1, 1'b0);
    check_req(1'b1, 8'd0, 5'd9,  3'd1, 8'h21, 2'd0, 32'h0000_0077, 1'b0, 1'b0, 1'b1);
    check_req(1'b0, 8'd0, 5'd9,  3'd1, 8'h20, 2'd2, 32'd0, 1'b0, 1'b0, 1'b1);

    for (int i = 0; i < 150; i++) begin
      logic [7:0] b;
      b = ($urandom % 2 == 0) ? 8'd0 : 8'($urandom);
      check_req(1'($urandom), b, 5'($urandom), 3'($urandom), 8'($urandom), 2'($urandom),
                $urandom, ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 8) == 0);
    end
    summary_and_end();
  end

endmodule